// File: doc/BRIEF.md
# Anti-howling attenuator switch controller

This block keeps a two-way voice path from howling by always placing a fixed 6 dB cut on exactly one of the two directions. Once per 8 kHz frame it takes one linear PCM sample from each direction. These are the near-end send input and the far-end receive input. It judges each direction active or silent, then attenuates either the send-output path or the receive-input path. The choice comes from a fixed truth table. When only the far end is talking, the send output is cut. In every other case the receive input is cut.

An input counts as active when the magnitude of its sample is strictly greater than a threshold supplied on a port. A hangover counter keeps a direction active for `HANG_FRAMES` frames after its activity stops, so short pauses do not make the attenuator flip back and forth. The feature is switched by an active-low enable pin. That pin is captured only when a frame starts, which is the falling edge of the frame strobe, and in the first clock after reset is released. When the cascade-slave strap is high, the block acts as if the enable pin were tied low, so the feature is always on.

Processed samples and the two status flags change in the clock after the edge at which the frame strobe is first sampled low. Between frames they hold steady.

Top module: `att_ctrl`

## Requirements
- R1: With the feature on, a frame whose receive input is active and whose send input is silent sets `att_tx_on`=1 and `att_rx_on`=0, and cuts `tx_out`.
- R2: With the feature on, every other activity combination sets `att_rx_on`=1 and `att_tx_on`=0, and cuts `rx_out`. These combinations are: both silent, both active, and send-only active.
- R3: With the feature on, exactly one of `att_tx_on` and `att_rx_on` is 1. With it off, both are 0.
- R4: A cut sample is the input shifted arithmetically right by one bit (two's complement, so -1 stays -1). An uncut sample passes unchanged.
- R5: The enable pin `att_en_n` is active low (0 = on). It is captured only at a frame start (a 1-to-0 transition of `frame_n`) or in the first clock with `rst_n` high after reset. A change of the pin at any other time has no effect.
- R6: When `slave_mode` is 1 at a capture point, the feature is turned on whatever `att_en_n` holds.
- R7: With the feature off, `tx_out`=`tx_in` and `rx_out`=`rx_in` as captured, and both flags are 0.
- R8: A sample is active when its magnitude, taken as unsigned 16 bits (so -32768 gives 32768), is strictly greater than `act_thresh`.
- R9: After the last active frame of a direction, that direction still counts as active for the next `HANG_FRAMES` frames (default 3), and is silent in the frame after those.
- R10: While `rst_n` is 0, both outputs are 0 and both flags are 0. The feature is off and the hangover is cleared.
- R11: Samples and flags for a frame appear in the clock after the edge that first samples `frame_n` low. They hold until the next frame start, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Frame strobe; a 1-to-0 transition starts a frame |
| att_en_n | input | 1 | Active-low enable for the attenuation feature |
| slave_mode | input | 1 | Cascade-slave strap; 1 forces the feature on |
| act_thresh | input | 16 | Unsigned activity threshold |
| tx_in | input | 16 | Near-end send sample, two's complement |
| rx_in | input | 16 | Far-end receive sample, two's complement |
| tx_out | output | 16 | Processed send output |
| rx_out | output | 16 | Processed receive input |
| att_tx_on | output | 1 | Send-output attenuator engaged |
| att_rx_on | output | 1 | Receive-input attenuator engaged |

## Verification
The hardest situation to reach is a change of the enable pin that must be ignored. A plain frame-by-frame stimulus always moves the pin together with a frame start, so it never tests this. The bench therefore toggles `att_en_n` between frames, and also while `frame_n` is held low past its falling edge, and checks that the flags do not move. A second hard case is the hangover boundary. A direction must fall silent exactly `HANG_FRAMES` frames after its last activity. Directed frame runs reach this edge by pushing the receive side from active to silent while the send side stays quiet, and random frames with near-threshold magnitudes and -32768 cover the remaining cases.

// File: rtl/att_ctrl_pkg.sv
// Package: shared types for the anti-howling attenuator controller.
// Assumes two signal directions, indexed by dir_e.
package att_ctrl_pkg;
    typedef enum logic [0:0] {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        CUT_NONE = 2'b00,
        CUT_RX   = 2'b01,
        CUT_TX   = 2'b10
    } cut_sel_e;
endpackage

// File: rtl/att_act_detect.sv
// Activity detector for one direction. On each frame start it compares the
// sample magnitude with the threshold, then runs a hangover counter.
// Assumes frame_go is a single-cycle pulse and thresh is unsigned.
module att_act_detect #(
    parameter int W           = 16,
    parameter int HANG_FRAMES = 3,
    localparam int CW         = $clog2(HANG_FRAMES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_go,
    input  logic signed [W-1:0] sample,
    input  logic        [W-1:0] thresh,
    output logic                active
);
    localparam logic [CW-1:0] HANG_LOAD = CW'(HANG_FRAMES);

    logic [W-1:0]  mag;
    logic          raw_hit;
    logic [CW-1:0] hold_cnt;

    // Magnitude as an unsigned W-bit value, so the most negative value fits.
    always_comb begin
        mag     = sample[W-1] ? (~sample + 1'b1) : sample;
        raw_hit = (mag > thresh);
    end

    // Update the active flag and the hangover counter once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            active   <= 1'b0;
        end else if (frame_go) begin
            active <= raw_hit || (hold_cnt != '0);
            if (raw_hit)
                hold_cnt <= HANG_LOAD;
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/att_select.sv
// Truth table choosing which path to attenuate. Receive-only activity cuts the
// send output; every other case cuts the receive input; disabled cuts none.
module att_select
    import att_ctrl_pkg::*;
(
    input  logic     enable,
    input  logic     tx_act,
    input  logic     rx_act,
    output cut_sel_e sel
);
    // Combinational placement decision.
    always_comb begin
        if (!enable)
            sel = CUT_NONE;
        else if (rx_act && !tx_act)
            sel = CUT_TX;
        else
            sel = CUT_RX;
    end
endmodule

// File: rtl/att_path.sv
// One signal path: passes the sample, or halves it (6 dB) with an arithmetic
// shift when cut is set. Assumes two's complement samples.
module att_path #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] din,
    input  logic                cut,
    output logic signed [W-1:0] dout
);
    // Select the halved or the unchanged sample.
    always_comb begin
        dout = cut ? (din >>> 1) : din;
    end
endmodule

// File: rtl/att_ctrl.sv
// Top of the anti-howling attenuator controller. Detects frame starts,
// captures samples and the enable pin, and engages one attenuator per frame.
// Assumes frame_n, att_en_n and slave_mode are synchronous to clk.
module att_ctrl
    import att_ctrl_pkg::*;
#(
    parameter int W           = 16,
    parameter int HANG_FRAMES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                att_en_n,
    input  logic                slave_mode,
    input  logic        [W-1:0] act_thresh,
    input  logic signed [W-1:0] tx_in,
    input  logic signed [W-1:0] rx_in,
    output logic signed [W-1:0] tx_out,
    output logic signed [W-1:0] rx_out,
    output logic                att_tx_on,
    output logic                att_rx_on
);
    localparam int NDIR = 2;

    logic                frame_prev;
    logic                rst_seen;
    logic                frame_go;
    logic                rel_go;
    logic                en_q;
    logic signed [W-1:0] tx_s;
    logic signed [W-1:0] rx_s;
    logic                tx_act;
    logic                rx_act;
    logic signed [W-1:0] smp_in [NDIR];
    logic                act_v  [NDIR];
    cut_sel_e            sel;

    // Pulses for the frame start (strobe falling) and the reset release.
    always_comb begin
        frame_go = frame_prev && !frame_n;
        rel_go   = !rst_seen;
    end

    // Edge history for the strobe and the reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_prev <= 1'b1;
            rst_seen   <= 1'b0;
        end else begin
            frame_prev <= frame_n;
            rst_seen   <= 1'b1;
        end
    end

    // Capture the enable (a slave is treated as tied low) at the allowed points.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (frame_go || rel_go)
            en_q <= slave_mode || !att_en_n;
    end

    // Hold the frame's samples until the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_s <= '0;
            rx_s <= '0;
        end else if (frame_go) begin
            tx_s <= tx_in;
            rx_s <= rx_in;
        end
    end

    // Route the live inputs to the detector array.
    always_comb begin
        smp_in[DIR_TX] = tx_in;
        smp_in[DIR_RX] = rx_in;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_det
        att_act_detect #(
            .W           (W),
            .HANG_FRAMES (HANG_FRAMES)
        ) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .frame_go (frame_go),
            .sample   (smp_in[g]),
            .thresh   (act_thresh),
            .active   (act_v[g])
        );
    end

    // Name the per-direction activity flags.
    always_comb begin
        tx_act = act_v[DIR_TX];
        rx_act = act_v[DIR_RX];
    end

    att_select u_sel (
        .enable (en_q),
        .tx_act (tx_act),
        .rx_act (rx_act),
        .sel    (sel)
    );

    att_path #(.W(W)) u_tx_path (
        .din  (tx_s),
        .cut  (sel == CUT_TX),
        .dout (tx_out)
    );

    att_path #(.W(W)) u_rx_path (
        .din  (rx_s),
        .cut  (sel == CUT_RX),
        .dout (rx_out)
    );

    // Status flags follow the selection.
    always_comb begin
        att_tx_on = (sel == CUT_TX);
        att_rx_on = (sel == CUT_RX);
    end
endmodule

// File: rtl/att_ctrl_chk.sv
// Checker for att_ctrl: placement rules, exclusivity, cut arithmetic and
// enable capture. Attached to every att_ctrl instance by the bind below.
module att_ctrl_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_q,
    input logic                frame_go,
    input logic                rel_go,
    input logic                tx_act,
    input logic                rx_act,
    input logic signed [W-1:0] tx_s,
    input logic signed [W-1:0] rx_s,
    input logic signed [W-1:0] tx_out,
    input logic signed [W-1:0] rx_out,
    input logic                att_tx_on,
    input logic                att_rx_on
);
    p_tx_rule_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && rx_act && !tx_act) |-> (att_tx_on && !att_rx_on));

    p_rx_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !(rx_act && !tx_act)) |-> (att_rx_on && !att_tx_on));

    p_one_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> ($countones({att_tx_on, att_rx_on}) == 1));

    p_none_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> ({att_tx_on, att_rx_on} == 2'b00));

    p_half_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        att_tx_on |-> (tx_out == (tx_s >>> 1) && rx_out == rx_s));

    p_half_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        att_rx_on |-> (rx_out == (rx_s >>> 1) && tx_out == tx_s));

    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_go && !rel_go) |=> $stable(en_q));

    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (tx_out == tx_s && rx_out == rx_s));
endmodule

bind att_ctrl att_ctrl_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .frame_go  (frame_go),
    .rel_go    (rel_go),
    .tx_act    (tx_act),
    .rx_act    (rx_act),
    .tx_s      (tx_s),
    .rx_s      (rx_s),
    .tx_out    (tx_out),
    .rx_out    (rx_out),
    .att_tx_on (att_tx_on),
    .att_rx_on (att_rx_on)
);

// File: tb/sim_att_ctrl.sv
// Bench for att_ctrl: directed corners plus seeded random frames, checked
// against a frame-level model kept in the bench.
module sim_att_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int HANG       = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                frame_n = 1'b1;
    logic                att_en_n = 1'b1;
    logic                slave_mode = 1'b0;
    logic        [W-1:0] act_thresh = 16'd1000;
    logic signed [W-1:0] tx_in = '0;
    logic signed [W-1:0] rx_in = '0;
    logic signed [W-1:0] tx_out;
    logic signed [W-1:0] rx_out;
    logic                att_tx_on;
    logic                att_rx_on;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    bit m_en = 0;
    int m_cnt_tx = 0;
    int m_cnt_rx = 0;
    bit m_at = 0;
    bit m_ar = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    att_ctrl #(.W(W), .HANG_FRAMES(HANG)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .att_en_n   (att_en_n),
        .slave_mode (slave_mode),
        .act_thresh (act_thresh),
        .tx_in      (tx_in),
        .rx_in      (rx_in),
        .tx_out     (tx_out),
        .rx_out     (rx_out),
        .att_tx_on  (att_tx_on),
        .att_rx_on  (att_rx_on)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mag_of(logic signed [W-1:0] x);
        return (x < 0) ? -int'(x) : int'(x);
    endfunction

    function automatic logic signed [W-1:0] half(logic signed [W-1:0] x);
        return x >>> 1;
    endfunction

    // One frame: drive, update the model, then check outputs after the update.
    task automatic run_frame(logic signed [W-1:0] tx, logic signed [W-1:0] rx,
                             bit en_n, bit slv);
        bit rt, rr, at, ar;
        string tag;
        @(negedge clk);
        tx_in = tx; rx_in = rx; att_en_n = en_n; slave_mode = slv;
        frame_n = 1'b0;
        m_en = slv || !en_n;
        rt = mag_of(tx) > int'(act_thresh);
        rr = mag_of(rx) > int'(act_thresh);
        at = rt || (m_cnt_tx != 0);
        ar = rr || (m_cnt_rx != 0);
        m_cnt_tx = rt ? HANG : (m_cnt_tx != 0 ? m_cnt_tx - 1 : 0);
        m_cnt_rx = rr ? HANG : (m_cnt_rx != 0 ? m_cnt_rx - 1 : 0);
        m_at = m_en && ar && !at;
        m_ar = m_en && !m_at;
        @(negedge clk);
        frame_n = 1'b1;
        tag = !m_en ? "R7" : (m_at ? "R1" : "R2");
        check(tag, int'(att_tx_on), int'(m_at));
        check(tag, int'(att_rx_on), int'(m_ar));
        check(m_at ? "R4 tx" : "R7 tx", int'(tx_out), int'(m_at ? half(tx) : tx));
        check(m_ar ? "R4 rx" : "R7 rx", int'(rx_out), int'(m_ar ? half(rx) : rx));
    endtask

    task automatic do_reset(bit en_n);
        @(negedge clk);
        rst_n = 1'b0; att_en_n = en_n; slave_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 tx_out", int'(tx_out), 0);
        check("R10 rx_out", int'(rx_out), 0);
        check("R10 flags", int'({att_tx_on, att_rx_on}), 0);
        rst_n = 1'b1;
        m_cnt_tx = 0; m_cnt_rx = 0;
        m_en = !en_n;
        @(negedge clk);
        // release captured the pin; both sides silent
        check("R5 release capture", int'(att_rx_on), int'(m_en));
        check("R5 release tx flag", int'(att_tx_on), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(1'b1);  // pin high at release: off
        do_reset(1'b0);  // pin low at release: on

        // R2 both silent, R1 rx only, R2 both active, R2 tx only
        run_frame(16'sd10, 16'sd20, 1'b0, 1'b0);
        run_frame(16'sd5, 16'sd5000, 1'b0, 1'b0);
        check("R1 rx-only flag", int'(att_tx_on), 1);
        run_frame(16'sd4000, -16'sd4000, 1'b0, 1'b0);
        check("R2 both active", int'(att_rx_on), 1);
        repeat (HANG + 1) run_frame(16'sd0, 16'sd0, 1'b0, 1'b0);
        run_frame(-16'sd3000, 16'sd0, 1'b0, 1'b0);
        check("R2 tx only", int'(att_rx_on), 1);
        repeat (HANG + 1) run_frame(16'sd0, 16'sd0, 1'b0, 1'b0);

        // R9 hangover: rx active once, then HANG silent frames stay active
        run_frame(16'sd0, 16'sd9000, 1'b0, 1'b0);
        for (int i = 0; i < HANG; i++) begin
            run_frame(16'sd0, 16'sd0, 1'b0, 1'b0);
            check("R9 hang held", int'(att_tx_on), 1);
        end
        run_frame(16'sd0, 16'sd0, 1'b0, 1'b0);
        check("R9 hang expired", int'(att_tx_on), 0);

        // R8 threshold boundary and most negative value
        run_frame(16'sd0, 16'sd1000, 1'b0, 1'b0);
        check("R8 equal not active", int'(att_tx_on), 0);
        run_frame(16'sd0, -16'sd1001, 1'b0, 1'b0);
        check("R8 above active", int'(att_tx_on), 1);
        repeat (HANG + 1) run_frame(16'sd0, 16'sd0, 1'b0, 1'b0);
        act_thresh = 16'd32767;
        run_frame(16'sd0, -16'sd32768, 1'b0, 1'b0);
        check("R8 min value active", int'(att_tx_on), 1);
        check("R4 min halved", int'(tx_out), 0);
        run_frame(16'sd32767, -16'sd1, 1'b0, 1'b0);
        act_thresh = 16'd1000;
        repeat (HANG + 1) run_frame(16'sd0, 16'sd0, 1'b0, 1'b0);
        run_frame(-16'sd1, 16'sd0, 1'b0, 1'b0);
        check("R4 minus one", int'(rx_out), 0);

        // R5 pin change between frames ignored
        @(negedge clk); att_en_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 ignore between frames", int'(att_rx_on), 1);
        // R5 pin change while strobe held low ignored; R11 samples held
        @(negedge clk); frame_n = 1'b0; att_en_n = 1'b0;
        tx_in = 16'sd50; rx_in = 16'sd60;
        @(negedge clk); att_en_n = 1'b1; tx_in = 16'sd777; rx_in = 16'sd888;
        repeat (3) @(negedge clk);
        check("R5 ignore while low", int'(att_rx_on), 1);
        check("R11 tx held", int'(tx_out), 50);
        check("R11 rx held", int'(rx_out), 30);
        frame_n = 1'b1;
        m_en = 1'b1; m_cnt_tx = 0; m_cnt_rx = 0;

        // R7 disabled, R6 slave forces on
        run_frame(16'sd100, 16'sd9000, 1'b1, 1'b0);
        check("R7 disabled flags", int'({att_tx_on, att_rx_on}), 0);
        run_frame(16'sd100, 16'sd9000, 1'b1, 1'b1);
        check("R6 slave forces on", int'(att_tx_on), 1);

        // random frames
        for (int i = 0; i < 400; i++) begin
            logic signed [W-1:0] t, r;
            int k = int'($urandom % 4);
            t = W'($urandom);
            r = W'($urandom);
            if (k == 0) t = W'(int'($urandom % 2001) - 1000);
            if (k == 1) r = W'(int'($urandom % 2001) - 1000);
            if ($urandom % 3 == 0) t = '0;
            run_frame(t, r, bit'($urandom % 4 == 0), bit'($urandom % 10 == 0));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule